// File: doc/BRIEF.md
# AXI ID-Filtered Transaction Event Source

This block watches the address and read-data handshakes of an AXI port and turns the traffic that belongs to a chosen set of transaction IDs into event strobes for a performance counter bank. It produces three strobes: one for accepted read addresses, one for accepted write addresses, and one for every accepted read data beat. Each strobe has its own enable. All three share a single masked ID compare: an ID qualifies when the ID bits selected by the mask equal the same bits of a programmed reference ID.

Two 32-bit configuration words program the block through a simple write port. The word at byte offset 0x00 holds the three enables and the mask. The word at byte offset 0x04 holds the reference ID. In the counter bank, the read-transaction strobe feeds counter 2, the write-transaction strobe feeds counter 3 and the read-beat strobe feeds counter 4. Each is picked there with event code 73. Every strobe is a registered pulse, high for one cycle for each qualifying handshake.

Top module: `axi_id_event_filter`

## Requirements
- R1: Reset (rst_n low, asynchronous) drives all three strobes low and clears the enables, mask and reference ID. After reset, handshakes produce no strobe until a filter is enabled again.
- R2: A write with cfg_addr = 0x00 loads the read-transaction enable from bit 31, the write-transaction enable from bit 30, the read-beat enable from bit 29, and the ID mask from bits 17:0.
- R3: A write with cfg_addr = 0x04 loads the reference ID from bits 17:0. Bits 31:18 of that word, bits 28:18 of the word at 0x00, and writes to any other address have no effect on filtering.
- R4: An observed ID matches when (ID AND mask) equals (reference AND mask). With a mask of zero, every ID matches.
- R5: An AR handshake (ar_valid and ar_ready both high) with a matching ar_id, while the read-transaction filter is enabled, gives a pulse on evt_rd_txn.
- R6: An AW handshake with a matching aw_id, while the write-transaction filter is enabled, gives a pulse on evt_wr_txn.
- R7: Every R handshake with a matching r_id gives a pulse on evt_rd_beat while the read-beat filter is enabled. This includes the last beat, so back-to-back beats give back-to-back pulses.
- R8: While a filter's enable is clear, its strobe stays low whatever the traffic.
- R9: A valid without ready, or a ready without valid, gives no strobe.
- R10: Each strobe is registered. It rises in the cycle after the handshake and lasts exactly one cycle per handshake.
- R11: The three filters act independently, so handshakes in the same cycle on all three channels give pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (8) | Byte offset of the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W (18) | Read address ID |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W (18) | Write address ID |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | ID_W (18) | Read data ID |
| evt_rd_txn | output | 1 | Filtered read-transaction pulse |
| evt_wr_txn | output | 1 | Filtered write-transaction pulse |
| evt_rd_beat | output | 1 | Filtered read-beat pulse |

## Verification
The bench builds the block with its default values, ID_W = 18 and ADDR_W = 8. At these values the top ID bit 17 and the reserved bits just above it lie inside the 32-bit words, so the bench can check both that bit 17 takes part in the compare and that bits above the ID field are ignored. The 8-bit offset leaves room for writes to unused addresses such as 0x08 and 0x01, which must not disturb the two real words.

// File: rtl/axi_id_event_filter.sv
module axi_id_event_filter #(
  parameter int ID_W   = 18,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  output logic              evt_rd_txn,
  output logic              evt_wr_txn,
  output logic              evt_rd_beat
);

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_REF  = ADDR_W'(4);
  localparam int NCH = 3;

  logic [NCH-1:0]  en_q;
  logic [ID_W-1:0] mask_q;
  logic [ID_W-1:0] ref_q;
  logic [NCH-1:0]  hs;
  logic [NCH-1:0]  evt_q;
  logic [ID_W-1:0] obs_id [NCH];
  logic            unused_cfg;

  assign unused_cfg = ^cfg_wdata[28:ID_W];

  // channel order: 0 = read address, 1 = write address, 2 = read data
  assign hs        = {r_valid & r_ready, aw_valid & aw_ready, ar_valid & ar_ready};
  assign obs_id[0] = ar_id;
  assign obs_id[1] = aw_id;
  assign obs_id[2] = r_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      ref_q  <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == OFS_CTRL) begin
        en_q   <= {cfg_wdata[29], cfg_wdata[30], cfg_wdata[31]};
        mask_q <= cfg_wdata[ID_W-1:0];
      end else if (cfg_addr == OFS_REF) begin
        ref_q  <= cfg_wdata[ID_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = ~|((obs_id[g] ^ ref_q) & mask_q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q[g] <= 1'b0;
      else        evt_q[g] <= en_q[g] & hs[g] & hit;
    end
  end

  assign evt_rd_txn  = evt_q[0];
  assign evt_wr_txn  = evt_q[1];
  assign evt_rd_beat = evt_q[2];

  p_rd_needs_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_txn |-> $past(ar_valid && ar_ready));

  p_wr_needs_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_txn |-> $past(aw_valid && aw_ready));

  p_beat_needs_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_beat |-> $past(r_valid && r_ready));

  p_off_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !(evt_rd_txn || evt_wr_txn || evt_rd_beat));

  p_open_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 && en_q[2] && r_valid && r_ready) |=> evt_rd_beat);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ar_valid && ar_ready) |=> !evt_rd_txn);

endmodule

// File: tb/test_axi_id_event_filter.sv
`timescale 1ns/1ps
module test_axi_id_event_filter;

  typedef struct packed {
    logic [31:0] c0;
    logic [31:0] c1;
    logic [2:0]  v;    // {r, aw, ar}
    logic [2:0]  rdy;  // {r, aw, ar}
    logic [17:0] ida;
    logic [17:0] idw;
    logic [17:0] idr;
    logic [2:0]  exp;  // {beat, wr, rd}
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{32'hE003FFFF, 32'h00012345, 3'b111, 3'b111, 18'h12345, 18'h12345, 18'h12345, 3'b111}, // R5 R6 R7 R11
    '{32'hE003FFFF, 32'h00012345, 3'b111, 3'b111, 18'h12344, 18'h12345, 18'h12345, 3'b110}, // R4 mismatch
    '{32'hE0000000, 32'h0002AAAA, 3'b111, 3'b111, 18'h00001, 18'h3FFFF, 18'h15555, 3'b111}, // R4 open mask
    '{32'hE00000FF, 32'h000000A5, 3'b111, 3'b111, 18'h3F0A5, 18'h001A5, 18'h000A4, 3'b011}, // R4 partial
    '{32'h8003FFFF, 32'h00000777, 3'b111, 3'b111, 18'h00777, 18'h00777, 18'h00777, 3'b001}, // R2 bit31
    '{32'h4003FFFF, 32'h00000777, 3'b111, 3'b111, 18'h00777, 18'h00777, 18'h00777, 3'b010}, // R2 bit30
    '{32'h2003FFFF, 32'h00000777, 3'b111, 3'b111, 18'h00777, 18'h00777, 18'h00777, 3'b100}, // R2 bit29
    '{32'hE003FFFF, 32'h00000777, 3'b101, 3'b110, 18'h00777, 18'h00777, 18'h00777, 3'b100}, // R9
    '{32'h0003FFFF, 32'h00000777, 3'b111, 3'b111, 18'h00777, 18'h00777, 18'h00777, 3'b000}, // R8
    '{32'hFFFFFFFF, 32'hFFFC0001, 3'b111, 3'b111, 18'h00001, 18'h00001, 18'h00001, 3'b111}  // R3 reserved bits
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ar_valid = 1'b0, ar_ready = 1'b0;
  logic        aw_valid = 1'b0, aw_ready = 1'b0;
  logic        r_valid = 1'b0, r_ready = 1'b0;
  logic [17:0] ar_id = '0, aw_id = '0, r_id = '0;
  logic        evt_rd_txn, evt_wr_txn, evt_rd_beat;
  logic [2:0]  evt;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  assign evt = {evt_rd_beat, evt_wr_txn, evt_rd_txn};

  always #2 clk = ~clk;

  axi_id_event_filter i_axi_id_event_filter (
    .clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata,
    .ar_valid, .ar_ready, .ar_id,
    .aw_valid, .aw_ready, .aw_id,
    .r_valid, .r_ready, .r_id,
    .evt_rd_txn, .evt_wr_txn, .evt_rd_beat
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic drive(input logic [2:0] v, input logic [2:0] rdy,
                       input logic [17:0] ia, input logic [17:0] iw, input logic [17:0] ir);
    ar_valid = v[0]; aw_valid = v[1]; r_valid = v[2];
    ar_ready = rdy[0]; aw_ready = rdy[1]; r_ready = rdy[2];
    ar_id = ia; aw_id = iw; r_id = ir;
  endtask

  task automatic one_shot(input string req, input logic [2:0] v, input logic [2:0] rdy,
                          input logic [17:0] ia, input logic [17:0] iw, input logic [17:0] ir,
                          input logic [2:0] exp);
    drive(v, rdy, ia, iw, ir);
    @(negedge clk);
    chk(req, evt, exp);
    drive(3'b000, 3'b000, '0, '0, '0);
    @(negedge clk);
    chk("R10 single-cycle pulse", evt, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", evt, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    one_shot("R1 cleared enables", 3'b111, 3'b111, '0, '0, '0, 3'b000);

    for (int i = 0; i < NV; i++) begin
      wr_cfg(8'h00, VEC[i].c0);
      wr_cfg(8'h04, VEC[i].c1);
      one_shot($sformatf("R2 R4 R5 R6 R7 vector %0d", i), VEC[i].v, VEC[i].rdy,
               VEC[i].ida, VEC[i].idw, VEC[i].idr, VEC[i].exp);
    end

    // R7: back-to-back beats, last beat included
    wr_cfg(8'h00, 32'h20000000);
    @(negedge clk);
    drive(3'b100, 3'b100, '0, '0, 18'h2BEEF);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk($sformatf("R7 burst beat %0d", k), evt, 3'b100);
    end
    drive(3'b000, 3'b000, '0, '0, '0);
    @(negedge clk);
    chk("R7 burst end", evt, 3'b000);

    // R3: stray addresses leave configuration intact; bit 17 compared
    wr_cfg(8'h00, 32'hE003FFFF);
    wr_cfg(8'h04, 32'h00020005);
    wr_cfg(8'h08, 32'h00000000);
    wr_cfg(8'h01, 32'h00000000);
    one_shot("R3 stray writes ignored", 3'b111, 3'b111, 18'h20005, 18'h20005, 18'h00005, 3'b011);

    // R1: reset mid-operation clears configuration
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset again", evt, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    one_shot("R1 config cleared", 3'b111, 3'b111, 18'h20005, 18'h20005, 18'h20005, 3'b000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule